// File: doc/BRIEF.md
# Fractional microsecond timebase counter

This block derives a 1 MHz tick enable from whatever oscillator clock it runs on. A programmable fraction (dividend over divisor) drives an accumulator. On every clock the accumulator gains the dividend. Whenever it reaches the divisor, the divisor is taken back out and one tick is issued. An oscillator whose frequency is not a whole number of megahertz, such as 19.2 MHz, therefore still yields exactly one tick per microsecond on average. Integer rates such as 12 MHz use a dividend of one, so the block acts as a plain divider.

A free-running microsecond counter advances by one on every tick. Software reads it through a simple synchronous read/write register port, and the same port holds the ratio setting. The tick output is a clock enable that other timers in the system share.

Top module: `usec_timebase`

## Requirements
- R1: After reset the ratio setting reads 0x0000000B, the counter reads zero, the tick is low, and the first tick appears on the 12th clock edge after reset is released.
- R2: The ratio setting is written at byte address 0x14. Bits [7:0] hold divisor minus one and bits [15:8] hold dividend minus one. On each clock edge the accumulator adds the dividend. If the sum is at least the divisor, the divisor is subtracted and a tick is issued. As a result, setting 0x045F gives exactly 50 ticks in the 960 edges that follow the write.
- R3: The tick output is high for exactly the clock cycle after an edge that issued a tick. The counter rises by one, modulo its width, on precisely the edges that raise the tick, and otherwise holds its value.
- R4: A dividend larger than the divisor is treated as equal to the divisor, so the tick stays high on every clock.
- R5: A write to 0x14 stores bits [15:0] of the write data, and upper bits read back as zero. The write clears the accumulator, issues no tick on that edge and leaves the counter unchanged. The new ratio applies from the next edge.
- R6: A read of byte address 0x10 returns the counter, zero-extended, as it stood before the read edge. The read data is registered and valid in the cycle after the read. With no read, the read data holds its value.
- R7: Writes to 0x10 or to any address other than 0x14 change nothing, and reads of any address other than 0x10 and 0x14 return zero.
- R8: The counter wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| tick_1us | output | 1 | One-cycle 1 MHz tick enable |

## Verification
The bench builds the block with an 8-bit counter and keeps the default 8-bit ratio fields and 32-bit data path. The narrow counter lets the bench reach the wrap from all ones to zero within a few hundred clocks when the ratio is set to tick on every clock. The default field width still allows the full set of oscillator ratios, including the fractional 5/96 and 5/84 settings, and a clamped setting where the dividend exceeds the divisor.

// File: rtl/usec_timebase_pkg.sv
package usec_timebase_pkg;

  // Byte addresses of the two registers (software relies on these).
  localparam logic [15:0] ADDR_COUNT = 16'h0010;
  localparam logic [15:0] ADDR_RATIO = 16'h0014;

  // Reset ratio: dividend 1, divisor 12.
  localparam logic [15:0] RATIO_RESET = 16'h000B;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_RATIO = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [15:0] a);
    if (a == ADDR_COUNT)      return SEL_COUNT;
    else if (a == ADDR_RATIO) return SEL_RATIO;
    else                      return SEL_NONE;
  endfunction

endpackage

// File: rtl/usec_ratio_accum.sv
module usec_ratio_accum #(
  parameter int FIELD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*FIELD_W-1:0] ratio_i,
  input  logic                 clear_i,
  output logic                 tick_hit_o,
  output logic                 tick_o
);

  localparam int ACC_W = FIELD_W;
  localparam int VAL_W = FIELD_W + 1;
  localparam int SUM_W = FIELD_W + 2;

  // Field value plus one, widened so the full range fits.
  function automatic logic [VAL_W-1:0] plus_one(input logic [FIELD_W-1:0] f);
    return VAL_W'(f) + VAL_W'(1);
  endfunction

  // Dividend clamped to the divisor: at most one tick per clock.
  function automatic logic [VAL_W-1:0] clamp_step(input logic [VAL_W-1:0] step,
                                                  input logic [VAL_W-1:0] lim);
    return (step > lim) ? lim : step;
  endfunction

  logic [VAL_W-1:0] divisor;
  logic [VAL_W-1:0] dividend_raw;
  logic [VAL_W-1:0] dividend;
  logic [SUM_W-1:0] sum;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             hit;

  assign divisor      = plus_one(ratio_i[FIELD_W-1:0]);
  assign dividend_raw = plus_one(ratio_i[2*FIELD_W-1:FIELD_W]);
  assign dividend     = clamp_step(dividend_raw, divisor);
  assign sum          = SUM_W'(acc_q) + SUM_W'(dividend);
  assign hit          = !clear_i && (sum >= SUM_W'(divisor));

  always_comb begin
    if (clear_i)  acc_d = '0;
    else if (hit) acc_d = ACC_W'(sum - SUM_W'(divisor));
    else          acc_d = ACC_W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_o <= hit;
    end
  end

  assign tick_hit_o = hit;

  AST_ACC_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (VAL_W'(acc_q) < divisor)); // R2

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (acc_q == '0) && !tick_o); // R5

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && (dividend_raw >= divisor)) |=> tick_o); // R4

endmodule

// File: rtl/usec_count.sv
module usec_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (inc_i) count_q <= count_q + CNT_W'(1);
  end

  assign count_o = count_q;

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((&count_q) && inc_i) |=> (count_q == '0)); // R8

endmodule

// File: rtl/usec_regfile.sv
module usec_regfile
  import usec_timebase_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CFG_W-1:0]  ratio_o,
  output logic              ratio_wr_o,
  output logic [DATA_W-1:0] rdata_o
);

  reg_sel_e          sel;
  logic [CFG_W-1:0]  ratio_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  assign sel        = decode_addr(16'(addr_i));
  assign ratio_wr_o = wr_i && (sel == SEL_RATIO);

  always_comb begin
    case (sel)
      SEL_COUNT: rd_mux = DATA_W'(count_i);
      SEL_RATIO: rd_mux = DATA_W'(ratio_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= CFG_W'(RATIO_RESET);
      rdata_q <= '0;
    end else begin
      if (ratio_wr_o) ratio_q <= wdata_i[CFG_W-1:0];
      if (rd_i)       rdata_q <= rd_mux;
    end
  end

  assign ratio_o = ratio_q;
  assign rdata_o = rdata_q;

  AST_RD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel == SEL_COUNT) |=> (rdata_q == DATA_W'($past(count_i)))); // R6

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_q)); // R6

  AST_RATIO_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel == SEL_RATIO) |=> ((rdata_q >> CFG_W) == '0)); // R5

  AST_RATIO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_wr_o |=> $stable(ratio_q)); // R7

endmodule

// File: rtl/usec_timebase.sv
module usec_timebase #(
  parameter int FIELD_W = 8,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tick_1us
);

  localparam int CFG_W = 2 * FIELD_W;

  logic [CFG_W-1:0] ratio_w;
  logic             ratio_wr_w;
  logic             tick_hit_w;
  logic             tick_q_w;
  logic [CNT_W-1:0] count_w;

  usec_regfile #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CFG_W  (CFG_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr),
    .rd_i       (reg_rd),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .count_i    (count_w),
    .ratio_o    (ratio_w),
    .ratio_wr_o (ratio_wr_w),
    .rdata_o    (reg_rdata)
  );

  usec_ratio_accum #(
    .FIELD_W (FIELD_W)
  ) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .ratio_i    (ratio_w),
    .clear_i    (ratio_wr_w),
    .tick_hit_o (tick_hit_w),
    .tick_o     (tick_q_w)
  );

  usec_count #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (tick_hit_w),
    .count_o (count_w)
  );

  assign tick_1us = tick_q_w;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q_w |-> (count_w == $past(count_w) + CNT_W'(1))); // R3

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_q_w |-> $stable(count_w)); // R3

  AST_WRITE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_wr_w |=> $stable(count_w)); // R5

endmodule

// File: tb/usec_timebase_bench.sv
module usec_timebase_bench;

  localparam int CNT_W   = 8;
  localparam int CNT_MOD = 1 << CNT_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = 8'h10;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_1us;

  int n_tests = 0;
  int n_fail  = 0;
  bit running = 1'b0;

  // Behavioural reference state
  int m_cfg = 32'h000B, m_acc = 0, m_cnt = 0, m_tick = 0;
  int m_rdata = 0;
  int tick_log[$];
  int cyc = 0;

  always #2 clk = ~clk;

  usec_timebase #(
    .FIELD_W (8),
    .CNT_W   (CNT_W),
    .ADDR_W  (8),
    .DATA_W  (32)
  ) u_usec_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tick_1us  (tick_1us)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Reference model: updated on each edge from the bench's own inputs
  always @(posedge clk) begin
    int dv, dd, s;
    cyc++;
    if (!rst_n) begin
      m_cfg = 32'h000B; m_acc = 0; m_cnt = 0; m_tick = 0; m_rdata = 0;
    end else begin
      if (reg_rd)
        m_rdata = (reg_addr == 8'h10) ? m_cnt : (reg_addr == 8'h14) ? m_cfg : 0;
      if (reg_wr && reg_addr == 8'h14) begin
        m_cfg = reg_wdata & 32'hFFFF;
        m_acc = 0;
        m_tick = 0;
      end else begin
        dv = (m_cfg & 255) + 1;
        dd = ((m_cfg >> 8) & 255) + 1;
        if (dd > dv) dd = dv;
        s = m_acc + dd;
        if (s >= dv) begin
          m_tick = 1; m_acc = s - dv; m_cnt = (m_cnt + 1) % CNT_MOD;
          tick_log.push_back(cyc);
        end else begin
          m_tick = 0; m_acc = s;
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R2 R3 tick vs model", {31'b0, tick_1us}, m_tick);
      chk("R3 R5 R6 read data vs model", reg_rdata, m_rdata);
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h10;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    reg_addr = 8'h10;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int first;
    int ticks;
    int prev;
    bit wrapped;
    logic [31:0] held;

    repeat (4) @(negedge clk);
    chk("R1 reset tick low", {31'b0, tick_1us}, 0);
    chk("R1 reset read data zero", reg_rdata, 0);
    reg_rd = 1'b1;
    rst_n = 1'b1;
    running = 1'b1;

    // R1: first tick on the 12th edge
    first = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (tick_1us && first == 0) first = k;
    end
    chk("R1 first tick edge", first, 12);
    rd_check("R1 reset ratio", 8'h14, 32'h0000_000B);

    // R2: 13 MHz integer ratio, tick spacing from the model's log
    wr_reg(8'h14, 32'h0000_000C);
    repeat (60) @(negedge clk);
    chk("R2 13-clock spacing", tick_log[$] - tick_log[$-1], 13);

    // R2: 5/96 ratio gives 50 ticks in 960 edges
    wr_reg(8'h14, 32'h0000_045F);
    ticks = 0;
    for (int i = 0; i < 960; i++) begin
      @(negedge clk);
      if (tick_1us) ticks++;
    end
    chk("R2 5/96 tick count", ticks, 50);

    // R2: other oscillator settings, model compared each clock
    wr_reg(8'h14, 32'h0000_04BF);
    repeat (400) @(negedge clk);
    wr_reg(8'h14, 32'h0000_0019);
    repeat (100) @(negedge clk);
    wr_reg(8'h14, 32'h0000_002F);
    repeat (100) @(negedge clk);

    // R4: dividend 6 over divisor 3 clamps to tick every clock
    wr_reg(8'h14, 32'h0000_0502);
    ticks = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick_1us) ticks++;
    end
    chk("R4 clamped full rate", ticks, 20);

    // R5: write while ticking every clock: no tick on the write edge
    wr_reg(8'h14, 32'h0000_0000);
    repeat (5) @(negedge clk);
    wr_reg(8'h14, 32'hABCD_0453);
    chk("R5 no tick on write edge", {31'b0, tick_1us}, 0);
    rd_check("R5 upper bits dropped", 8'h14, 32'h0000_0453);

    // R7: writes elsewhere ignored, unmapped read is zero
    wr_reg(8'h10, 32'h0000_00FF);
    wr_reg(8'h20, 32'h0000_0000);
    rd_check("R7 ratio unchanged", 8'h14, 32'h0000_0453);
    rd_check("R7 unmapped read zero", 8'h20, 32'h0);
    wr_reg(8'h24, 32'h0000_0000);
    rd_check("R7 ratio still unchanged", 8'h14, 32'h0000_0453);

    // R6: read data holds while no read is issued
    @(negedge clk);
    reg_rd = 1'b0;
    held = reg_rdata;
    repeat (30) @(negedge clk);
    chk("R6 read data held", reg_rdata, held);
    reg_rd = 1'b1;

    // R8: wrap of the counter at full rate
    wr_reg(8'h14, 32'h0000_0000);
    wrapped = 1'b0;
    prev = -1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (prev == CNT_MOD - 1 && reg_rdata == 0) wrapped = 1'b1;
      prev = int'(reg_rdata);
    end
    chk("R8 counter wrapped to zero", {31'b0, wrapped}, 1);

    running = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule